// File: doc/BRIEF.md
# Interval Timer Match Interrupt Unit

This block is a timer interrupt source for a processor core. It keeps a free-running 64-bit interval count that advances once every `TICK_DIV` core clocks. Alongside the count sit a match register and a vector/mask register. When the count arrives at the match value, the unit latches a pending interrupt. While the timer is unmasked, that pending interrupt drives a request line, and the request carries the stored 8-bit vector number. A single-cycle acknowledge input retires the request.

Software reaches all state through one register port. The count is never cleared or reloaded by a match. To get periodic interrupts, software adds a fixed delta to the current count after each interrupt and writes the result as the next match. If that write arrives late, the match value already sits at or behind the count and no interrupt comes at the intended time. The unit records such a write in a sticky status bit so the lost interrupt can be seen.

Register addresses on `reg_addr`: 0 = count, 1 = match, 2 = vector/mask, 3 = status.

Top module: `itm_timer_unit`

## Requirements
- R1: After reset the count reads 0, the match reads 0, the vector register reads 0x10000 (masked, vector 0), the status reads 0, and `irq_req` is low.
- R2: The count advances by exactly one on every `TICK_DIV`-th rising clock edge after reset release, namely edge k with k mod `TICK_DIV` = 0 (first edge after release is k = 1), and holds between those edges.
- R3: A write to address 0 loads the count with `reg_wdata`. When the write lands on an advancing edge, the written value wins with no extra increment, and counting continues from it.
- R4: A match does not clear, reload or stop the count, which keeps advancing past the match value.
- R5: When the count takes a new value, by increment or by write, and that value equals the match register, the pending flag (status bit 1) is set on the following edge. `irq_req` is high while pending is set and mask is clear. `irq_vec` always shows vector bits [7:0].
- R6: With mask (vector register bit 16) set, `irq_req` stays low but the pending flag is still set and kept. Clearing the mask then raises `irq_req` with the stored vector.
- R7: The pending flag is cleared by a one-cycle `irq_ack` or by any write to the match register.
- R8: A match write whose value is at or below the count at that moment sets the missed flag (status bit 0). A write above the count leaves it unchanged. The flag stays set until a write to address 3 with bit 0 = 1 clears it.
- R9: A match written at or below the current count produces no interrupt at the time of the write, nor while the count moves on past it.
- R10: Vector register layout: bits [7:0] vector, bit 16 mask, all other bits read 0 and ignore written values. The status register reads 0 above bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 count, 1 match, 2 vector/mask, 3 status) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr`, combinational |
| irq_req | output | 1 | Timer interrupt request (pending and unmasked) |
| irq_vec | output | 8 | Vector number sent with the request |
| irq_ack | input | 1 | Interrupt acknowledge, one cycle |

## Verification
A software write to the count and a prescaler advance can land on the same edge. The bench counts edges since reset release, so it can steer a count write exactly onto an advancing edge. It then expects the written value back, not that value plus one, and expects the next increment a full `TICK_DIV` edges later. A second collision puts a count write that equals the match value on that same kind of edge. The bench judges it by the pending request that appears one edge afterward.

// File: rtl/itm_pkg.sv
package itm_pkg;

  typedef enum logic [1:0] {
    RA_COUNT  = 2'd0,
    RA_MATCH  = 2'd1,
    RA_VECTOR = 2'd2,
    RA_STATUS = 2'd3
  } reg_addr_e;

  localparam int MASK_BIT  = 16;
  localparam int ST_MISSED = 0;
  localparam int ST_PEND   = 1;

endpackage

// File: rtl/itm_tick_gen.sv
module itm_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

      logic [DW-1:0] div_q;

      function automatic logic [DW-1:0] f_div_next(input logic [DW-1:0] d);
        return (d == LAST) ? '0 : d + 1'b1;
      endfunction

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= f_div_next(div_q);
      end

      assign tick = (div_q == LAST);

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick) else $error("tick on consecutive edges"); // R2
    end
  endgenerate

endmodule

// File: rtl/itm_count_reg.sv
module itm_count_reg #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             upd_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] f_count_next(
    input logic [CNT_W-1:0] cur,
    input logic             wr,
    input logic [CNT_W-1:0] wd,
    input logic             tk
  );
    if (wr)      return wd;
    else if (tk) return cur + ONE;
    else         return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= f_count_next(cnt_q, wr_en, wr_data, tick);
      upd_q <= wr_en | tick;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en |=> cnt_q == $past(cnt_q) + ONE) else $error("count step"); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_en |=> $stable(cnt_q)) else $error("count moved"); // R2
  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt_q == $past(wr_data)) else $error("write lost"); // R3

endmodule

// File: rtl/itm_match_ctl.sv
module itm_match_ctl #(
  parameter int CNT_W = 64,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             cnt_upd_q,
  input  logic             match_wr,
  input  logic [CNT_W-1:0] match_wdata,
  input  logic             vec_wr,
  input  logic [VEC_W-1:0] vec_wdata,
  input  logic             mask_wdata,
  input  logic             miss_clr,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] match_q,
  output logic [VEC_W-1:0] vec_q,
  output logic             mask_q,
  output logic             pending_q,
  output logic             missed_q
);

  logic hit;
  logic late_wr;

  function automatic logic f_is_late(input logic [CNT_W-1:0] newm,
                                     input logic [CNT_W-1:0] cur);
    return newm <= cur;
  endfunction

  function automatic logic f_hit(input logic upd,
                                 input logic [CNT_W-1:0] cur,
                                 input logic [CNT_W-1:0] m);
    return upd && (cur == m);
  endfunction

  assign hit     = f_hit(cnt_upd_q, cnt_q, match_q);
  assign late_wr = match_wr && f_is_late(match_wdata, cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      vec_q   <= '0;
      mask_q  <= 1'b1;
    end else begin
      if (match_wr) match_q <= match_wdata;
      if (vec_wr) begin
        vec_q  <= vec_wdata;
        mask_q <= mask_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending_q <= 1'b0;
    else if (match_wr) pending_q <= 1'b0;
    else if (hit)      pending_q <= 1'b1;
    else if (irq_ack)  pending_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        missed_q <= 1'b0;
    else if (late_wr)  missed_q <= 1'b1;
    else if (miss_clr) missed_q <= 1'b0;
  end

  AST_HIT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !match_wr |=> pending_q) else $error("hit lost"); // R5
  AST_MASK_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q && pending_q && !irq_ack && !match_wr |=> pending_q) else $error("pend dropped"); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !hit |=> !pending_q) else $error("ack ignored"); // R7
  AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    match_wr |=> !pending_q) else $error("rearm kept pend"); // R7
  AST_LATE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    match_wr && (match_wdata <= cnt_q) |=> missed_q) else $error("late not flagged"); // R8
  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    missed_q && !miss_clr |=> missed_q) else $error("missed dropped"); // R8

endmodule

// File: rtl/itm_timer_unit.sv
module itm_timer_unit #(
  parameter int CNT_W    = 64,
  parameter int VEC_W    = 8,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  input  logic             irq_ack
);
  import itm_pkg::*;

  reg_addr_e        addr;
  logic             tick;
  logic             cnt_wr, match_wr, vec_wr, miss_clr;
  logic [CNT_W-1:0] cnt_q, match_q;
  logic             cnt_upd_q;
  logic [VEC_W-1:0] vec_q;
  logic             mask_q, pending_q, missed_q;

  assign addr     = reg_addr_e'(reg_addr);
  assign cnt_wr   = reg_wr && (addr == RA_COUNT);
  assign match_wr = reg_wr && (addr == RA_MATCH);
  assign vec_wr   = reg_wr && (addr == RA_VECTOR);
  assign miss_clr = reg_wr && (addr == RA_STATUS) && reg_wdata[ST_MISSED];

  function automatic logic [CNT_W-1:0] f_vec_word(input logic [VEC_W-1:0] v,
                                                  input logic m);
    logic [CNT_W-1:0] w;
    w = '0;
    w[VEC_W-1:0] = v;
    w[MASK_BIT]  = m;
    return w;
  endfunction

  function automatic logic [CNT_W-1:0] f_status_word(input logic pend,
                                                     input logic miss);
    logic [CNT_W-1:0] w;
    w = '0;
    w[ST_PEND]   = pend;
    w[ST_MISSED] = miss;
    return w;
  endfunction

  itm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  itm_count_reg #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(cnt_wr), .wr_data(reg_wdata),
    .cnt_q(cnt_q), .upd_q(cnt_upd_q)
  );

  itm_match_ctl #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_match (
    .clk(clk), .rst_n(rst_n),
    .cnt_q(cnt_q), .cnt_upd_q(cnt_upd_q),
    .match_wr(match_wr), .match_wdata(reg_wdata),
    .vec_wr(vec_wr), .vec_wdata(reg_wdata[VEC_W-1:0]),
    .mask_wdata(reg_wdata[MASK_BIT]),
    .miss_clr(miss_clr), .irq_ack(irq_ack),
    .match_q(match_q), .vec_q(vec_q), .mask_q(mask_q),
    .pending_q(pending_q), .missed_q(missed_q)
  );

  always_comb begin
    unique case (addr)
      RA_COUNT:  reg_rdata = cnt_q;
      RA_MATCH:  reg_rdata = match_q;
      RA_VECTOR: reg_rdata = f_vec_word(vec_q, mask_q);
      default:   reg_rdata = f_status_word(pending_q, missed_q);
    endcase
  end

  assign irq_req = pending_q & ~mask_q;
  assign irq_vec = vec_q;

  AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(pending_q) || $past(cnt_upd_q)) else $error("spurious req"); // R5
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_wr |=> $stable(irq_vec)) else $error("vector changed"); // R10

endmodule

// File: tb/itm_timer_unit_test.sv
module itm_timer_unit_test;
  localparam int DIV_T = 4;
  localparam int N_TBL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic        irq_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  bit done   = 1'b0;

  // {wr, addr[1:0], wdata[63:0], expected read[63:0]}
  localparam logic [130:0] TBL [N_TBL] = '{
    {1'b0, 2'd2, 64'h0, 64'h10000},
    {1'b0, 2'd1, 64'h0, 64'h0},
    {1'b0, 2'd3, 64'h0, 64'h0},
    {1'b1, 2'd2, 64'hAB, 64'hAB},
    {1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h100FF},
    {1'b1, 2'd1, 64'h1234_0000_0000, 64'h1234_0000_0000},
    {1'b0, 2'd3, 64'h0, 64'h0},
    {1'b1, 2'd2, 64'h10000, 64'h10000}
  };
  localparam string TAGS [N_TBL] = '{"R1", "R1", "R1", "R10", "R10", "R10", "R8", "R10"};

  itm_timer_unit #(.CNT_W(64), .VEC_W(8), .TICK_DIV(DIV_T)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
  );

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [63:0] c;
    int guard;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, before any edge after release
    rd(2'd0, v); chk("R1 count", v, 64'h0);
    chk("R1 irq_req", {63'b0, irq_req}, 64'h0);

    // register table
    for (int i = 0; i < N_TBL; i++) begin
      if (TBL[i][130]) wr(TBL[i][129:128], TBL[i][127:64]);
      rd(TBL[i][129:128], v);
      chk(TAGS[i], v, TBL[i][63:0]);
    end
    chk("R1 irq low masked", {63'b0, irq_req}, 64'h0);

    // R3 count write landing on an advancing edge
    while (((edges + 1) % DIV_T) != 0) @(negedge clk);
    wr(2'd0, 64'h40);
    rd(2'd0, v); chk("R3 write beats tick", v, 64'h40);
    cycles(DIV_T - 1);
    rd(2'd0, v); chk("R2 hold between ticks", v, 64'h40);
    cycles(1);
    rd(2'd0, v); chk("R2 one step per period", v, 64'h41);

    // R5 match reached by counting
    wr(2'd2, 64'h5A);
    wr(2'd0, 64'hFE);
    wr(2'd1, 64'h100);
    rd(2'd3, v); chk("R8 ahead write not missed", v, 64'h0);
    reg_addr = 2'd0;
    guard = 0;
    #1 c = reg_rdata;
    while (c != 64'h100 && guard < 40) begin
      @(negedge clk); #1 c = reg_rdata; guard++;
    end
    chk("R5 count reached match", c, 64'h100);
    chk("R5 no req same cycle", {63'b0, irq_req}, 64'h0);
    @(negedge clk);
    chk("R5 req raised", {63'b0, irq_req}, 64'h1);
    chk("R5 vector", {56'b0, irq_vec}, 64'h5A);
    cycles(DIV_T + 1);
    rd(2'd0, v); chk("R4 count ran past match", {63'b0, (v > 64'h100)}, 64'h1);
    chk("R7 pending held without ack", {63'b0, irq_req}, 64'h1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R7 ack clears req", {63'b0, irq_req}, 64'h0);
    rd(2'd3, v); chk("R7 pending bit clear", v, 64'h0);

    // R6 masked match; collision of count write and tick with equality
    wr(2'd2, 64'h1_0033);
    while (((edges + 1) % DIV_T) != 0) @(negedge clk);
    wr(2'd0, 64'h100);
    @(negedge clk);
    chk("R6 masked no req", {63'b0, irq_req}, 64'h0);
    rd(2'd3, v); chk("R6 pending kept masked", v, 64'h2);
    wr(2'd2, 64'h33);
    chk("R6 unmask raises req", {63'b0, irq_req}, 64'h1);
    chk("R6 vector after unmask", {56'b0, irq_vec}, 64'h33);
    wr(2'd1, 64'h2000);
    chk("R7 match rewrite clears req", {63'b0, irq_req}, 64'h0);

    // R8 / R9 late match writes
    wr(2'd0, 64'h500);
    wr(2'd1, 64'h400);
    rd(2'd3, v); chk("R8 behind sets missed", v, 64'h1);
    wr(2'd3, 64'h1);
    rd(2'd3, v); chk("R8 clear missed", v, 64'h0);
    wr(2'd0, 64'h700);
    wr(2'd1, 64'h700);
    rd(2'd3, v); chk("R8 equal sets missed", v, 64'h1);
    chk("R9 no req on equal write", {63'b0, irq_req}, 64'h0);
    cycles(3 * DIV_T);
    chk("R9 no req later", {63'b0, irq_req}, 64'h0);
    wr(2'd1, 64'h9000);
    rd(2'd3, v); chk("R8 sticky after ahead write", v, 64'h1);
    wr(2'd3, 64'h0);
    rd(2'd3, v); chk("R8 write bit0=0 keeps", v, 64'h1);
    wr(2'd3, 64'h1);
    rd(2'd3, v); chk("R8 cleared", v, 64'h0);

    // R10 readback of vector with other bits ignored
    wr(2'd2, 64'hFFFF_0000_0001_FF12);
    rd(2'd2, v); chk("R10 vector fields", v, 64'h1_0012);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule